// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This unit sits beside an ALU and turns each operation into a registered status word. Each cycle it receives four things. The first is the two operands. The second is the result the ALU produced. The third is an operation class: move, add, subtract or logic. The fourth is a width select for 8-bit or 16-bit operations.

From these it derives carry, parity, half-carry, zero, sign and overflow. Moves leave every flag as it was. A dedicated command clears carry alone. Three control flags are held in the same word and change only through their own set and clear commands: string direction, interrupt enable and single-step trap. Their values are offered to the sequencer and interrupt logic that use them.

All flags are registered. An operation presented before a rising clock edge is visible on the outputs after that edge. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `sfg_flag_unit`

## Requirements
- R1: Carry (word bit 0) is set when an add produces a carry, or a subtract needs a borrow, out of bit 7 for byte width (`wide`=0) or bit 15 for word width (`wide`=1).
- R2: Parity (bit 2) is 1 when bits 7..0 of the result contain an even number of ones and 0 when the count is odd, at either width.
- R3: Half-carry (bit 4) is set on a carry (add) or borrow (subtract) from bit 3 into bit 4, and is 0 otherwise.
- R4: Zero (bit 6) is set exactly when the result at the selected width is all zeros; result bits 15..8 are ignored for byte width.
- R5: Sign (bit 7) equals result bit 7 for byte width and result bit 15 for word width.
- R6: Overflow (bit 11) is set when a signed add or subtract leaves the two's-complement range of the selected width.
- R7: Operation class 0 (move or control transfer) leaves all six status flags unchanged; classes are 1 add, 2 subtract, 3 logic.
- R8: A logic operation clears carry, overflow and half-carry, and sets parity, zero and sign from the result.
- R9: Direction (bit 10), interrupt enable (bit 9) and trap (bit 8) each change only through their own set and clear inputs. When both are asserted together, clear wins.
- R10: `carry_clr` forces carry to 0 on the next edge, even over an operation's carry, and leaves every other flag as that cycle would have made it.
- R11: Bit 1 of the flag word is always 1, and bits 3, 5 and 15..12 are always 0. After reset every flag is 0, so the word reads 0x0002.
- R12: Flags reflect the operation on the first rising edge after it is presented. Inputs are ignored until two edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 2 | 0 move, 1 add, 2 subtract, 3 logic |
| wide | input | 1 | 1 selects 16-bit, 0 selects 8-bit |
| opnd_a | input | 16 | First operand (minuend for subtract) |
| opnd_b | input | 16 | Second operand (subtrahend) |
| result | input | 16 | ALU result for this operation |
| carry_clr | input | 1 | Clear carry only |
| dir_set | input | 1 | Set direction flag |
| dir_clr | input | 1 | Clear direction flag |
| irq_set | input | 1 | Set interrupt enable |
| irq_clr | input | 1 | Clear interrupt enable |
| trap_set | input | 1 | Set trap flag |
| trap_clr | input | 1 | Clear trap flag |
| flags_word | output | 16 | Packed flag word |
| cf | output | 1 | Carry |
| pf | output | 1 | Parity |
| af | output | 1 | Half-carry |
| zf | output | 1 | Zero |
| sf | output | 1 | Sign |
| of | output | 1 | Overflow |
| tf | output | 1 | Trap |
| ief | output | 1 | Interrupt enable |
| df | output | 1 | Direction |

## Verification
All flag state is on the outputs, so a wrong flag register shows up one edge after the operation that set it. A flag that is written when it should hold is different: a wrong update in a move cycle or a lost control-flag value stays hidden until the next cycle, when the held value is compared. A model in the bench recomputes every flag from integer arithmetic on each cycle, and compares it against the output after every edge. Directed corner cases and a long random stream are both used, so a width or borrow slip is seen within one cycle of the operation that exposes it.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic [1:0] {
    OPC_MOVE  = 2'd0,
    OPC_ADD   = 2'd1,
    OPC_SUB   = 2'd2,
    OPC_LOGIC = 2'd3
  } opc_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic hcy;
    logic par;
    logic cry;
  } stat_t;

  localparam int unsigned WORD_W  = 16;
  localparam int unsigned POS_CRY = 0;
  localparam int unsigned POS_ONE = 1;
  localparam int unsigned POS_PAR = 2;
  localparam int unsigned POS_HCY = 4;
  localparam int unsigned POS_ZRO = 6;
  localparam int unsigned POS_SGN = 7;
  localparam int unsigned POS_TRP = 8;
  localparam int unsigned POS_IEN = 9;
  localparam int unsigned POS_DIR = 10;
  localparam int unsigned POS_OVF = 11;
  localparam int unsigned NUM_CTRL = 3;
endpackage

// File: rtl/sfg_parity.sv
module sfg_parity #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] d,
  output logic         even
);
  logic [W:0] chain;
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_fold
    assign chain[i+1] = chain[i] ^ d[i];
  end
  assign even = chain[W];
endmodule

// File: rtl/sfg_status_calc.sv
module sfg_status_calc
  import sfg_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned NW  = 8,
  parameter int unsigned NIB = 4
) (
  input  opc_e          op,
  input  logic          wide,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] r,
  output stat_t         st
);
  localparam int unsigned MS_WIDE   = DW - 1;
  localparam int unsigned MS_NARROW = NW - 1;

  logic a_m, b_m, r_m;
  logic par_even;
  logic zero_n, zero_w;

  always_comb begin
    if (wide) begin
      a_m = a[MS_WIDE];
      b_m = b[MS_WIDE];
      r_m = r[MS_WIDE];
    end else begin
      a_m = a[MS_NARROW];
      b_m = b[MS_NARROW];
      r_m = r[MS_NARROW];
    end
  end

  sfg_parity #(.W(NW)) u_par (
    .d    (r[NW-1:0]),
    .even (par_even)
  );

  assign zero_n = (r[NW-1:0] == '0);
  assign zero_w = (r == '0);

  always_comb begin
    st     = '0;
    st.par = par_even;
    st.zro = wide ? zero_w : zero_n;
    st.sgn = r_m;
    unique case (op)
      OPC_ADD: begin
        st.cry = (a_m & b_m) | ((a_m | b_m) & ~r_m);
        st.hcy = a[NIB] ^ b[NIB] ^ r[NIB];
        st.ovf = (a_m == b_m) && (r_m != a_m);
      end
      OPC_SUB: begin
        st.cry = (~a_m & b_m) | ((~a_m | b_m) & r_m);
        st.hcy = a[NIB] ^ b[NIB] ^ r[NIB];
        st.ovf = (a_m != b_m) && (r_m != a_m);
      end
      default: begin
        st.cry = 1'b0;
        st.hcy = 1'b0;
        st.ovf = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sfg_ctrl_bit.sv
module sfg_ctrl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_nxt;
  logic q_en;

  assign q_en = set_i | clr_i;

  always_comb begin
    q_nxt = q;
    if (clr_i)      q_nxt = 1'b0;
    else if (set_i) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/sfg_rst_sync.sv
module sfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe[STAGES-1];
endmodule

// File: rtl/sfg_flag_unit.sv
module sfg_flag_unit
  import sfg_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned NW  = 8,
  parameter int unsigned NIB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_class,
  input  logic          wide,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] result,
  input  logic          carry_clr,
  input  logic          dir_set,
  input  logic          dir_clr,
  input  logic          irq_set,
  input  logic          irq_clr,
  input  logic          trap_set,
  input  logic          trap_clr,
  output logic [15:0]   flags_word,
  output logic          cf,
  output logic          pf,
  output logic          af,
  output logic          zf,
  output logic          sf,
  output logic          of,
  output logic          tf,
  output logic          ief,
  output logic          df
);
  logic  rst_sync_n;
  opc_e  op;
  stat_t calc_st;
  stat_t stat_q, stat_nxt;
  logic  stat_en;
  logic [NUM_CTRL-1:0] ctl_set, ctl_clr, ctl_q;

  sfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign op = opc_e'(op_class);

  sfg_status_calc #(.DW(DW), .NW(NW), .NIB(NIB)) u_calc (
    .op   (op),
    .wide (wide),
    .a    (opnd_a),
    .b    (opnd_b),
    .r    (result),
    .st   (calc_st)
  );

  assign stat_en = (op != OPC_MOVE) | carry_clr;

  always_comb begin
    stat_nxt = stat_q;
    if (op != OPC_MOVE) stat_nxt = calc_st;
    if (carry_clr)      stat_nxt.cry = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  stat_q <= '0;
    else if (stat_en) stat_q <= stat_nxt;
  end

  // control flags: index 0 trap, 1 interrupt enable, 2 direction
  assign ctl_set = {dir_set, irq_set, trap_set};
  assign ctl_clr = {dir_clr, irq_clr, trap_clr};

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctl
    sfg_ctrl_bit u_bit (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (ctl_set[k]),
      .clr_i (ctl_clr[k]),
      .q     (ctl_q[k])
    );
  end

  always_comb begin
    flags_word          = '0;
    flags_word[POS_ONE] = 1'b1;
    flags_word[POS_CRY] = stat_q.cry;
    flags_word[POS_PAR] = stat_q.par;
    flags_word[POS_HCY] = stat_q.hcy;
    flags_word[POS_ZRO] = stat_q.zro;
    flags_word[POS_SGN] = stat_q.sgn;
    flags_word[POS_OVF] = stat_q.ovf;
    flags_word[POS_TRP] = ctl_q[0];
    flags_word[POS_IEN] = ctl_q[1];
    flags_word[POS_DIR] = ctl_q[2];
  end

  assign cf  = stat_q.cry;
  assign pf  = stat_q.par;
  assign af  = stat_q.hcy;
  assign zf  = stat_q.zro;
  assign sf  = stat_q.sgn;
  assign of  = stat_q.ovf;
  assign tf  = ctl_q[0];
  assign ief = ctl_q[1];
  assign df  = ctl_q[2];
endmodule

// File: rtl/sfg_flag_unit_chk.sv
module sfg_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  op_class,
  input logic        wide,
  input logic [15:0] result,
  input logic        carry_clr,
  input logic        dir_set,
  input logic        dir_clr,
  input logic [15:0] flags_word
);
  // R7
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'd0 && !carry_clr) |=>
      $stable({flags_word[11], flags_word[7:6], flags_word[4], flags_word[2], flags_word[0]}));

  // R8
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'd3) |=> (!flags_word[0] && !flags_word[4] && !flags_word[11]));

  // R10
  carry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_clr |=> !flags_word[0]);

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_set && !dir_clr) |=> $stable(flags_word[10]));

  // R9
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_clr |=> !flags_word[10]);

  // R4
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_class == 2'd1 || op_class == 2'd2) && wide && result == 16'h0000) |=> flags_word[6]);
endmodule

bind sfg_flag_unit sfg_flag_unit_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .op_class   (op_class),
  .wide       (wide),
  .result     (result),
  .carry_clr  (carry_clr),
  .dir_set    (dir_set),
  .dir_clr    (dir_clr),
  .flags_word (flags_word)
);

// File: tb/sfg_flag_unit_tb.sv
module sfg_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op_class;
  logic        wide;
  logic [15:0] opnd_a, opnd_b, result;
  logic        carry_clr, dir_set, dir_clr, irq_set, irq_clr, trap_set, trap_clr;
  logic [15:0] flags_word;
  logic        cf, pf, af, zf, sf, of, tf, ief, df;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [15:0] exp_w = 16'h0002;

  always #2 clk = ~clk;

  sfg_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .wide(wide),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .carry_clr(carry_clr), .dir_set(dir_set), .dir_clr(dir_clr),
    .irq_set(irq_set), .irq_clr(irq_clr), .trap_set(trap_set), .trap_clr(trap_clr),
    .flags_word(flags_word), .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf),
    .of(of), .tf(tf), .ief(ief), .df(df)
  );

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // R12: compared one negedge after the edge that captured the inputs
  task automatic compare_all();
    chk("R1 R10 carry", cf, exp_w[0]);
    chk("R2 parity", pf, exp_w[2]);
    chk("R3 half-carry", af, exp_w[4]);
    chk("R4 zero", zf, exp_w[6]);
    chk("R5 sign", sf, exp_w[7]);
    chk("R6 overflow", of, exp_w[11]);
    chk("R9 trap", tf, exp_w[8]);
    chk("R9 irq enable", ief, exp_w[9]);
    chk("R9 direction", df, exp_w[10]);
    checks++;
    if (flags_word !== exp_w) begin
      fails++;
      $display("FAIL R11 word got=%h exp=%h", flags_word, exp_w);
    end
  endtask

  function automatic logic [15:0] model(logic [15:0] w, int op, bit wd,
      logic [15:0] a, logic [15:0] b, logic [15:0] r, bit cc, logic [5:0] cmd);
    logic [15:0] n = w;
    int mask = wd ? 16'hFFFF : 16'h00FF;
    int msb  = wd ? 15 : 7;
    int ua = int'(a) & mask, ub = int'(b) & mask, ur = int'(r) & mask;
    int sa = ua, sb = ub, s, ones = 0;
    if (ua > (mask >> 1)) sa = ua - (mask + 1);
    if (ub > (mask >> 1)) sb = ub - (mask + 1);
    if (op != 0) begin
      for (int i = 0; i < 8; i++) ones += r[i];
      n[2] = (ones % 2) == 0;
      n[6] = (ur == 0);
      n[7] = r[msb];
      if (op == 1) begin
        n[0] = (ua + ub) > mask;
        n[4] = ((ua & 15) + (ub & 15)) > 15;
        s = sa + sb;
        n[11] = (s > (mask >> 1)) || (s < -((mask >> 1) + 1));
      end else if (op == 2) begin
        n[0] = ua < ub;
        n[4] = (ua & 15) < (ub & 15);
        s = sa - sb;
        n[11] = (s > (mask >> 1)) || (s < -((mask >> 1) + 1));
      end else begin  // R8
        n[0] = 1'b0; n[4] = 1'b0; n[11] = 1'b0;
      end
    end
    if (cc) n[0] = 1'b0;  // R10
    // cmd = {dir_set, dir_clr, irq_set, irq_clr, trap_set, trap_clr}; clear wins
    if (cmd[4]) n[10] = 1'b0; else if (cmd[5]) n[10] = 1'b1;
    if (cmd[2]) n[9]  = 1'b0; else if (cmd[3]) n[9]  = 1'b1;
    if (cmd[0]) n[8]  = 1'b0; else if (cmd[1]) n[8]  = 1'b1;
    return n;
  endfunction

  // lsel selects the logic function: 0 and, 1 or, 2 xor
  task automatic step(int op, bit wd, logic [15:0] a, logic [15:0] b, int lsel,
      bit cc, logic [5:0] cmd);
    logic [15:0] r;
    @(negedge clk);
    compare_all();
    case (op)
      1: r = a + b;
      2: r = a - b;
      3: r = (lsel == 0) ? (a & b) : (lsel == 1) ? (a | b) : (a ^ b);
      default: r = 16'($urandom);
    endcase
    if (!wd) r[15:8] = 8'($urandom);  // R4: upper byte ignored at byte width
    op_class = 2'(op); wide = wd; opnd_a = a; opnd_b = b; result = r;
    carry_clr = cc;
    {dir_set, dir_clr, irq_set, irq_clr, trap_set, trap_clr} = cmd;
    exp_w = model(exp_w, op, wd, a, b, r, cc, cmd);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_class = 2'd0; wide = 1'b0;
    opnd_a = '0; opnd_b = '0; result = '0; carry_clr = 1'b0;
    {dir_set, dir_clr, irq_set, irq_clr, trap_set, trap_clr} = '0;
    repeat (5) @(negedge clk);
    compare_all();  // R11 reset word 0x0002
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0, 6'b0);  // R12 sync release window
    // R1 R3 R4 R2 byte carry to zero
    step(1, 0, 16'h12FF, 16'h3401, 0, 0, 6'b0);
    // R6 R5 byte signed overflow
    step(1, 0, 16'h007F, 16'h0001, 0, 0, 6'b0);
    // R7 move holds
    step(0, 1, 16'hFFFF, 16'hFFFF, 0, 0, 6'b0);
    // R6 word overflow on subtract
    step(2, 1, 16'h8000, 16'h0001, 0, 0, 6'b0);
    // R1 R3 word borrow
    step(2, 1, 16'h0000, 16'h0001, 0, 0, 6'b0);
    // R4 word zero
    step(2, 1, 16'h1234, 16'h1234, 0, 0, 6'b0);
    // R2 parity on low byte only at word width
    step(1, 1, 16'h0100, 16'h0003, 0, 0, 6'b0);
    // R8 logic after carry
    step(1, 1, 16'hFFFF, 16'h0001, 0, 0, 6'b0);
    step(3, 1, 16'hF0F0, 16'h8F0F, 2, 0, 6'b0);
    // R10 carry clear over an add that carries
    step(1, 0, 16'h00F0, 16'h0020, 0, 1, 6'b0);
    step(1, 1, 16'hFFFF, 16'h0002, 0, 0, 6'b0);
    step(0, 0, 0, 0, 0, 1, 6'b0);
    // R9 control flags: set, both (clear wins), hold
    step(0, 0, 0, 0, 0, 0, 6'b101010);
    step(0, 0, 0, 0, 0, 0, 6'b000000);
    step(0, 0, 0, 0, 0, 0, 6'b110000);
    step(0, 0, 0, 0, 0, 0, 6'b000011);
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 3);
      logic [15:0] a = 16'($urandom), b = 16'($urandom);
      logic [5:0] cmd = '0;
      if ($urandom_range(0, 3) == 0) a = 16'h8000 | 16'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) b = a;
      if ($urandom_range(0, 4) == 0) cmd = 6'($urandom);
      step(op, 1'($urandom), a, b, $urandom_range(0, 2),
           $urandom_range(0, 7) == 0, cmd);
    end
    step(0, 0, 0, 0, 0, 0, 6'b0);
    @(negedge clk);
    compare_all();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule